// File: doc/BRIEF.md
# Request-Triggered Serial ID Responder

This block answers a one-bit request strobe from a host by sending a fixed identifier word on a single serial data line. It sends one bit per clock cycle, most significant bit first, and then goes back to idle. It is a Moore machine with one idle state and one dedicated state per identifier bit. A shift register is not used. The state register holds the index of the bit being sent, and code zero means idle.

A busy flag is high for the whole transmission. While it is high the request input is not looked at, so a second strobe cannot cut a word short or restart it. The identifier and its width are parameters. The default is a 4-bit word of value 1101. With that default the state register is 3 bits wide. Code 000 is idle and codes 001 to 100 send bits 3, 2, 1 and 0. Codes above the last transmit code are never entered, and if one is ever reached the machine goes back to idle on the next edge. Both outputs are registered.

Top module: `serial_id_responder`

## Requirements
- R1: When the synchronous active-high reset is sampled at a rising edge, both `ser_out` and `busy` are 0 after that edge.
- R2: While idle, if `req` is sampled as 0 at a rising edge, the block stays idle after that edge with `ser_out` = 0 and `busy` = 0.
- R3: While idle, if `req` is sampled as 1 at a rising edge, `busy` is 1 after that edge and `ser_out` holds identifier bit `ID_W-1`.
- R4: The identifier is sent most significant bit first, one bit per clock cycle. With the default `ID_VALUE` = 4'b1101, the sequence on `ser_out` is 1, 1, 0, 1.
- R5: `busy` stays high for exactly `ID_W` consecutive cycles. After the last bit the block returns to idle whatever the value of `req`, so `busy` and `ser_out` are 0 for at least one cycle.
- R6: A value on `req` while `busy` is high has no effect. The bits that are sent and the length of the word stay the same, and a strobe that ends before the word is finished does not start a new transmission.
- R7: A reset applied in the middle of a transmission stops it. After that edge `ser_out` and `busy` are 0, and the block then waits for a new request.
- R8: The identifier comes from the `ID_VALUE` parameter. An instance built with a different value (for example 4'b0110) sends that value in the same order and with the same timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request strobe, sampled only while idle |
| ser_out | output | 1 | Serial identifier bit, registered |
| busy | output | 1 | High while identifier bits are being sent, registered |

## Verification
Both outputs come from registers that load the decode of the next state. A request sampled at edge k therefore shows its first bit right after edge k, and bit i shows after edge k+i. `busy` falls after edge k+`ID_W`, and a reset sampled at an edge clears both outputs after that same edge. The bench drives inputs at the falling edge. It samples the outputs one nanosecond after each rising edge, so every check looks at the value that the edge just loaded. Each check is compared against an expected value worked out from the edge count.

// File: rtl/serial_id_pkg.sv
package serial_id_pkg;

  // State code zero is the idle state; code k (1..ID_W) transmits bit ID_W-k.
  localparam int unsigned IDLE_CODE = 0;

  function automatic int unsigned state_width(input int unsigned id_w);
    return $clog2(id_w + 1);
  endfunction

endpackage

// File: rtl/sid_next_state.sv
module sid_next_state
  import serial_id_pkg::*;
#(
  parameter int unsigned ID_W = 4,
  localparam int unsigned SW  = state_width(ID_W)
) (
  input  logic [SW-1:0] state_q,
  input  logic          req,
  output logic [SW-1:0] state_d
);

  localparam logic [SW-1:0] IDLE = SW'(IDLE_CODE);
  localparam logic [SW-1:0] LAST = SW'(ID_W);

  always_comb begin
    if (state_q == IDLE) begin
      state_d = req ? SW'(1) : IDLE;
    end else if (state_q < LAST) begin
      state_d = state_q + SW'(1);
    end else begin
      // The last transmit code and all unused codes go back to idle.
      state_d = IDLE;
    end
  end

endmodule

// File: rtl/sid_output_decode.sv
module sid_output_decode
  import serial_id_pkg::*;
#(
  parameter int unsigned   ID_W     = 4,
  parameter logic [ID_W-1:0] ID_VALUE = 4'b1101,
  localparam int unsigned  SW       = state_width(ID_W)
) (
  input  logic [SW-1:0] state,
  output logic          bit_out,
  output logic          in_tx
);

  logic [ID_W-1:0] hit;

  // One comparator per transmit state; state k selects bit ID_W-k.
  for (genvar k = 1; k <= ID_W; k++) begin : g_sel
    assign hit[ID_W-k] = (state == SW'(k));
  end

  assign in_tx   = |hit;
  assign bit_out = |(hit & ID_VALUE);

endmodule

// File: rtl/serial_id_responder.sv
module serial_id_responder
  import serial_id_pkg::*;
#(
  parameter int unsigned     ID_W     = 4,
  parameter logic [ID_W-1:0] ID_VALUE = 4'b1101
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic ser_out,
  output logic busy
);

  localparam int unsigned SW = state_width(ID_W);

  logic [SW-1:0] state_q;
  logic [SW-1:0] state_d;
  logic          bit_d;
  logic          busy_d;

  sid_next_state #(.ID_W(ID_W)) u_next (
    .state_q (state_q),
    .req     (req),
    .state_d (state_d)
  );

  // Decode the next state so the registered outputs line up with state_q.
  sid_output_decode #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dec (
    .state   (state_d),
    .bit_out (bit_d),
    .in_tx   (busy_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SW'(IDLE_CODE);
      ser_out <= 1'b0;
      busy    <= 1'b0;
    end else begin
      state_q <= state_d;
      ser_out <= bit_d;
      busy    <= busy_d;
    end
  end

endmodule

// File: rtl/serial_id_responder_chk.sv
module serial_id_responder_chk #(
  parameter int unsigned     ID_W     = 4,
  parameter logic [ID_W-1:0] ID_VALUE = 4'b1101
) (
  input logic clk,
  input logic rst,
  input logic req,
  input logic ser_out,
  input logic busy
);

  localparam int unsigned CW = $clog2(ID_W + 1);

  // Number of busy cycles already seen in the current word.
  logic [CW-1:0] run;
  always_ff @(posedge clk) begin
    if (rst || !busy) run <= '0;
    else              run <= run + CW'(1);
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!busy && !ser_out));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !req) |=> (!busy && !ser_out));

  a_r3_start: assert property (@(posedge clk) disable iff (rst)
    (!busy && req) |=> (busy && ser_out == ID_VALUE[ID_W-1]));

  a_r4_bit_order: assert property (@(posedge clk) disable iff (rst)
    (busy && run < CW'(ID_W)) |-> (ser_out == ID_VALUE[ID_W-1-int'(run)]));

  a_r5_length: assert property (@(posedge clk) disable iff (rst)
    (busy && run == CW'(ID_W-1)) |=> (!busy && !ser_out));

  a_r6_no_cut: assert property (@(posedge clk) disable iff (rst)
    (busy && run < CW'(ID_W-1)) |=> busy);

  always_comb begin
    if (!rst) a_r4_idle_low: assert (busy || !ser_out);
  end

endmodule

bind serial_id_responder serial_id_responder_chk #(
  .ID_W(ID_W), .ID_VALUE(ID_VALUE)
) u_chk (
  .clk(clk), .rst(rst), .req(req), .ser_out(ser_out), .busy(busy)
);

// File: tb/test_serial_id_responder.sv
`timescale 1ns/1ps
module test_serial_id_responder;

  localparam logic [3:0] ID_A = 4'b1101;
  localparam logic [3:0] ID_B = 4'b0110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic ser_a, busy_a, ser_b, busy_b;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  serial_id_responder #(.ID_W(4), .ID_VALUE(ID_A)) i_serial_id_responder (
    .clk(clk), .rst(rst), .req(req), .ser_out(ser_a), .busy(busy_a));

  serial_id_responder #(.ID_W(4), .ID_VALUE(ID_B)) i_serial_id_responder_alt (
    .clk(clk), .rst(rst), .req(req), .ser_out(ser_b), .busy(busy_b));

  task automatic check(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  // Drive at the falling edge, then sample 1 ns after the next rising edge.
  task automatic step(input logic r, input logic rs);
    @(negedge clk);
    req = r;
    rst = rs;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    check(ser_a, 1'b0, "R1 ser_out after reset");
    check(busy_a, 1'b0, "R1 busy after reset");
  endtask

  task automatic t_idle();
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b0);
      check(busy_a, 1'b0, "R2 busy idle");
      check(ser_a, 1'b0, "R2 ser_out idle");
    end
  endtask

  // Full word; hold_req keeps req high during transmission (R6).
  task automatic t_word(input logic hold_req);
    step(1'b1, 1'b0);
    check(busy_a, 1'b1, "R3 busy after request");
    check(ser_a, ID_A[3], "R3 first bit");
    check(ser_b, ID_B[3], "R8 first bit alt");
    for (int i = 2; i >= 0; i--) begin
      step(hold_req, 1'b0);
      check(busy_a, 1'b1, hold_req ? "R6 busy held" : "R5 busy held");
      check(ser_a, ID_A[i], hold_req ? "R6 bit unchanged" : "R4 bit order");
      check(ser_b, ID_B[i], "R8 alt bit order");
    end
    step(hold_req, 1'b0);
    check(busy_a, 1'b0, "R5 busy drops after last bit");
    check(ser_a, 1'b0, "R5 ser_out low after word");
  endtask

  task automatic t_short_strobe_while_busy();
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    check(ser_a, ID_A[0], "R6 last bit");
    step(1'b0, 1'b0);
    check(busy_a, 1'b0, "R6 no restart");
    step(1'b0, 1'b0);
    check(busy_a, 1'b0, "R6 still idle");
  endtask

  task automatic t_abort();
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    check(busy_a, 1'b1, "R7 busy before abort");
    step(1'b0, 1'b1);
    check(busy_a, 1'b0, "R7 busy after abort");
    check(ser_a, 1'b0, "R7 ser_out after abort");
    step(1'b0, 1'b0);
    check(busy_a, 1'b0, "R7 idle after abort");
    step(1'b1, 1'b0);
    check(ser_a, ID_A[3], "R7 restart first bit");
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    check(busy_a, 1'b0, "R7 word done");
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_word(1'b0);
    t_word(1'b1);
    t_idle();
    t_short_strobe_while_busy();
    t_abort();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule